// File: doc/BRIEF.md
# Keyboard matrix scanner with serial link

This block scans a key matrix laid out as 16 rows by 8 columns, a 128-position key space in which the unused positions of a smaller physical matrix act as extra inputs. A 4-bit row index walks all rows in ascending order. It is expanded to 16 active-low row strobes by a cascade of 3-to-8 decoders, where the top index bit enables one decoder and the other decoder holds all its strobes high. Each row is held for a programmable settle time. The block then captures the 8 column inputs as one word and walks the columns one per cycle. It compares each sample against the previous scan and against the last reported state.

A change that is seen on two consecutive scans becomes an 8-bit event code, built as {release flag, row index, column index}. The code goes into a small queue and from there to a two-wire clocked serial link. The keyboard is normally the clock master. Each frame is 8 data bits with no parity, sent least significant bit first, and each bit lasts a fixed number of system cycles. While the link is idle, the host may pull the clock line low to ask to send. When the host releases the line, the block clocks in one byte from the data line and presents it on a one-cycle strobe.

The scan sequencer has two states. SC_SETTLE counts settle cycles with the row driven and moves to SC_CHECK when the count reaches the programmed value, capturing the columns as it leaves. SC_CHECK evaluates one column per cycle and returns to SC_SETTLE on the next row after the last column. The link has four states. LK_IDLE goes to LK_REQ when the host holds the clock low, which takes priority, or else to LK_TX when a code is queued. LK_REQ goes to LK_RX once the host releases the clock. LK_TX and LK_RX both return to LK_IDLE after the eighth bit period.

Top module: `kbd_matrix_link`

## Requirements
- R1: While reset is held and right after it, row 0 is the only row driven low (row_n = 16'hFFFE), the link clock and data outputs are high (released), overflow is 0 and rx_valid is 0.
- R2: Exactly one bit of row_n is low at all times, and row_n bit r is low when row r is selected. Rows are visited in the order 0,1,...,15,0. Index bit 3 selects the decoder for rows 8 to 15.
- R3: Each row stays selected for settle_cycles + 9 system cycles: settle_cycles + 1 before the columns are captured, then 8 for the column walk. A new settle_cycles value takes effect from the next row.
- R4: A column input low means the key is pressed. A key whose new state is seen on two consecutive scans is reported once. The code has bit 7 = 1 for a release and 0 for a press, bits 6:3 for the row and bits 2:0 for the column. Spare positions such as row 15, column 7 report like any other (0x7F press, 0xFF release).
- R5: A key state seen on only one scan, followed by a return to the earlier state, produces no code.
- R6: Several changes confirmed in the same row are sent in ascending column order, and keys that did not change produce no code.
- R7: A frame is 8 bits, least significant first. Each bit lasts 12 cycles: the clock is low for 6 cycles and then high for 6. Data changes only while the clock is low within a frame, and the data and clock lines are both high when idle.
- R8: Up to 4 codes wait in the queue behind the one being sent. A code arriving while the queue is full is dropped, and overflow goes to 1 and stays at 1 until reset.
- R9: If the host holds the link clock low while the link is idle, then after the host releases it the block gives 8 clock periods and samples the data line at each rising clock edge, least significant bit first. It then pulses rx_valid for one cycle with the byte on rx_byte. The block's data output stays high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| settle_cycles | input | 8 | Cycles a row is held before the first capture opportunity |
| col_n | input | 8 | Column inputs for the selected row, low = pressed |
| row_n | output | 16 | One-of-16 active-low row strobes |
| link_clk_i | input | 1 | Observed level of the shared link clock line |
| link_clk_o | output | 1 | Link clock drive, 0 = pull low, 1 = release |
| link_dat_i | input | 1 | Observed level of the shared link data line |
| link_dat_o | output | 1 | Link data drive, 0 = pull low, 1 = release |
| rx_byte | output | 8 | Byte received from the host |
| rx_valid | output | 1 | One-cycle strobe marking rx_byte |
| overflow | output | 1 | Sticky flag: a code was dropped because the queue was full |

## Verification
The assertions assume that the host pulls the clock line only while the link is idle, and that it changes the data line only while the clock is low during a host transfer. They also assume that the column inputs are steady during the cycle in which they are captured. The bench models the shared lines as wired-AND of both drivers. It waits for a quiet line before making a host request, and it sets the host data bit on each falling clock edge it sees. Key changes are applied away from the clock edge and one row at a time. The single-scan glitch is timed from the row strobes, so that it falls inside exactly one capture window.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    typedef enum logic [0:0] {
        SC_SETTLE = 1'b0,
        SC_CHECK  = 1'b1
    } scan_state_t;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_REQ  = 2'd1,
        LK_TX   = 2'd2,
        LK_RX   = 2'd3
    } link_state_t;

endpackage

// File: rtl/kbd_dec3to8_n.sv
module kbd_dec3to8_n (
    input  logic       en,
    input  logic [2:0] sel,
    output logic [7:0] out_n
);
    always_comb begin
        out_n = '1;
        if (en) out_n[sel] = 1'b0;
    end
endmodule

// File: rtl/kbd_row_decode.sv
module kbd_row_decode #(
    parameter int IW = 4
) (
    input  logic [IW-1:0]      idx,
    output logic [(1<<IW)-1:0] row_n
);
    localparam int ROWS   = 1 << IW;
    localparam int GROUPS = ROWS / 8;

    // Upper index bits enable exactly one 3-to-8 group; the rest stay all-high.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic en_g;
        assign en_g = (idx[IW-1:3] == (IW-3)'(g));
        kbd_dec3to8_n u_dec (
            .en   (en_g),
            .sel  (idx[2:0]),
            .out_n(row_n[g*8 +: 8])
        );
    end
endmodule

// File: rtl/kbd_scan.sv
module kbd_scan
    import kbd_pkg::*;
#(
    parameter int IW   = 4,
    parameter int COLS = 8,
    parameter int SW   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SW-1:0]         settle,
    input  logic [COLS-1:0]       col_n,
    output logic [IW-1:0]         row_idx,
    output logic                  evt_valid,
    output logic [IW+$clog2(COLS):0] evt_code
);
    localparam int ROWS = 1 << IW;
    localparam int CW   = $clog2(COLS);
    localparam int KEYS = ROWS * COLS;

    scan_state_t     state_q, state_d;
    logic [IW-1:0]   row_q;
    logic [SW-1:0]   cnt_q;
    logic [COLS-1:0] cap_q;
    logic [CW-1:0]   col_q;
    logic [KEYS-1:0] prev_q;
    logic [KEYS-1:0] stab_q;

    logic [IW+CW-1:0] key_idx;
    logic             raw;
    logic             hit;
    logic             settle_done;
    logic             last_col;

    assign key_idx     = {row_q, col_q};
    assign raw         = cap_q[col_q];
    // confirmed on two scans and different from what was last reported
    assign hit         = (raw == prev_q[key_idx]) && (raw != stab_q[key_idx]);
    assign settle_done = (cnt_q >= settle);
    assign last_col    = (col_q == CW'(COLS-1));
    assign row_idx     = row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SC_SETTLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_SETTLE: if (settle_done) state_d = SC_CHECK;
            SC_CHECK:  if (last_col)    state_d = SC_SETTLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q     <= '0;
            cnt_q     <= '0;
            cap_q     <= '0;
            col_q     <= '0;
            prev_q    <= '0;
            stab_q    <= '0;
            evt_valid <= 1'b0;
            evt_code  <= '0;
        end else begin
            evt_valid <= 1'b0;
            unique case (state_q)
                SC_SETTLE: begin
                    if (settle_done) begin
                        cap_q <= ~col_n;
                        cnt_q <= '0;
                        col_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SC_CHECK: begin
                    prev_q[key_idx] <= raw;
                    if (hit) begin
                        stab_q[key_idx] <= raw;
                        evt_valid       <= 1'b1;
                        evt_code        <= {~raw, row_q, col_q};
                    end
                    col_q <= col_q + 1'b1;
                    if (last_col) row_q <= row_q + 1'b1;
                end
            endcase
        end
    end

    // R3: the row index only ever advances by one
    a_r3_row_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (row_q != $past(row_q)) |-> (row_q == $past(row_q) + 1'b1));

    // R4: back-to-back reports always name different keys
    a_r4_distinct_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && $past(evt_valid)) |-> (evt_code != $past(evt_code)));

endmodule

// File: rtl/kbd_evt_fifo.sv
module kbd_evt_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          full;
    logic          push_ok, pop_ok;

    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q     <= '0;
            rp_q     <= '0;
            cnt_q    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (pop_ok)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + {{AW{1'b0}}, push_ok} - {{AW{1'b0}}, pop_ok};
            if (push && full) overflow <= 1'b1;
        end
    end

    // R8: once set, the drop flag holds until reset
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overflow) |-> overflow);

    // R8: occupancy never exceeds the configured depth
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (AW+1)'(DEPTH));

    // R8: the link only takes a code when one is waiting
    a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/kbd_link.sv
module kbd_link
    import kbd_pkg::*;
#(
    parameter int W       = 8,
    parameter int BIT_CYC = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_ready,
    input  logic [W-1:0] tx_data,
    output logic         tx_pop,
    input  logic         link_clk_i,
    input  logic         link_dat_i,
    output logic         link_clk_o,
    output logic         link_dat_o,
    output logic [W-1:0] rx_byte,
    output logic         rx_valid
);
    localparam int HALF  = BIT_CYC / 2;
    localparam int CNT_W = $clog2(BIT_CYC);
    localparam int BW    = $clog2(W);

    link_state_t      state_q, state_d;
    logic [1:0]       clk_s, dat_s;
    logic [CNT_W-1:0] cnt_q;
    logic [BW-1:0]    bit_q;
    logic [W-1:0]     sh_q;
    logic             clk_q, dat_q;
    logic             host_low, mid, end_bit, last_bit;

    assign host_low   = !clk_s[1];
    assign mid        = (cnt_q == CNT_W'(HALF-1));
    assign end_bit    = (cnt_q == CNT_W'(BIT_CYC-1));
    assign last_bit   = (bit_q == BW'(W-1));
    assign tx_pop     = (state_q == LK_IDLE) && !host_low && tx_ready;
    assign link_clk_o = clk_q;
    assign link_dat_o = dat_q;

    // two-stage synchronizers for the shared lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_s <= 2'b11;
            dat_s <= 2'b11;
        end else begin
            clk_s <= {clk_s[0], link_clk_i};
            dat_s <= {dat_s[0], link_dat_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE: if (host_low)              state_d = LK_REQ;
                     else if (tx_ready)         state_d = LK_TX;
            LK_REQ:  if (!host_low)             state_d = LK_RX;
            LK_TX:   if (end_bit && last_bit)   state_d = LK_IDLE;
            LK_RX:   if (end_bit && last_bit)   state_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            clk_q    <= 1'b1;
            dat_q    <= 1'b1;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state_q)
                LK_IDLE: begin
                    if (tx_pop) begin
                        sh_q  <= tx_data;
                        dat_q <= tx_data[0];
                        clk_q <= 1'b0;
                        cnt_q <= '0;
                        bit_q <= '0;
                    end
                end
                LK_REQ: begin
                    if (!host_low) begin
                        clk_q <= 1'b0;
                        cnt_q <= '0;
                        bit_q <= '0;
                    end
                end
                LK_TX: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (mid) clk_q <= 1'b1;
                    if (end_bit) begin
                        if (last_bit) begin
                            dat_q <= 1'b1;
                        end else begin
                            cnt_q <= '0;
                            bit_q <= bit_q + 1'b1;
                            clk_q <= 1'b0;
                            dat_q <= sh_q[1];
                            sh_q  <= {1'b1, sh_q[W-1:1]};
                        end
                    end
                end
                LK_RX: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (mid) begin
                        clk_q <= 1'b1;
                        sh_q  <= {dat_s[1], sh_q[W-1:1]};
                    end
                    if (end_bit) begin
                        if (last_bit) begin
                            rx_valid <= 1'b1;
                            rx_byte  <= sh_q;
                        end else begin
                            cnt_q <= '0;
                            bit_q <= bit_q + 1'b1;
                            clk_q <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    // R7: an idle link leaves both lines released
    a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_IDLE) |-> (link_clk_o && link_dat_o));

    // R7: data does not move while the clock is high inside a frame
    a_r7_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_TX && $past(state_q) == LK_TX && link_clk_o && $past(link_clk_o))
        |-> $stable(link_dat_o));

    // R9: the data line is left to the host during a request and receive
    a_r9_rx_data_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_REQ || state_q == LK_RX) |-> link_dat_o);

    // R9: the receive strobe lasts a single cycle
    a_r9_rx_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/kbd_matrix_link.sv
module kbd_matrix_link #(
    parameter int ROW_IW     = 4,
    parameter int COLS       = 8,
    parameter int SETTLE_W   = 8,
    parameter int BIT_CYC    = 12,
    parameter int FIFO_DEPTH = 4,
    localparam int ROWS      = 1 << ROW_IW,
    localparam int CODE_W    = 1 + ROW_IW + $clog2(COLS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [COLS-1:0]     col_n,
    output logic [ROWS-1:0]     row_n,
    input  logic                link_clk_i,
    output logic                link_clk_o,
    input  logic                link_dat_i,
    output logic                link_dat_o,
    output logic [CODE_W-1:0]   rx_byte,
    output logic                rx_valid,
    output logic                overflow
);
    logic [ROW_IW-1:0] row_idx;
    logic              evt_valid;
    logic [CODE_W-1:0] evt_code;
    logic [CODE_W-1:0] q_head;
    logic              q_empty;
    logic              q_pop;

    kbd_scan #(.IW(ROW_IW), .COLS(COLS), .SW(SETTLE_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .settle   (settle_cycles),
        .col_n    (col_n),
        .row_idx  (row_idx),
        .evt_valid(evt_valid),
        .evt_code (evt_code)
    );

    kbd_row_decode #(.IW(ROW_IW)) u_rowdec (
        .idx  (row_idx),
        .row_n(row_n)
    );

    kbd_evt_fifo #(.W(CODE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (evt_valid),
        .din     (evt_code),
        .pop     (q_pop),
        .dout    (q_head),
        .empty   (q_empty),
        .overflow(overflow)
    );

    kbd_link #(.W(CODE_W), .BIT_CYC(BIT_CYC)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_ready  (!q_empty),
        .tx_data   (q_head),
        .tx_pop    (q_pop),
        .link_clk_i(link_clk_i),
        .link_dat_i(link_dat_i),
        .link_clk_o(link_clk_o),
        .link_dat_o(link_dat_o),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid)
    );

    // R2: the cascaded decoders always leave exactly one strobe low
    a_r2_one_row_low: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_n) == ROWS - 1);

endmodule

// File: tb/tb_kbd_matrix_link.sv
module tb_kbd_matrix_link;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  settle_cycles = 8'd3;
    logic [7:0]  col_n;
    logic [15:0] row_n;
    logic        kb_clk_o, kb_dat_o;
    logic        host_clk = 1'b1, host_dat = 1'b1;
    logic        clk_line, dat_line;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic        overflow;
    logic [127:0] keys = '0;

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    assign clk_line = kb_clk_o & host_clk;
    assign dat_line = kb_dat_o & host_dat;

    always_comb begin
        col_n = '1;
        for (int r = 0; r < 16; r++)
            if (!row_n[r]) col_n = col_n & ~keys[r*8 +: 8];
    end

    kbd_matrix_link dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .settle_cycles(settle_cycles),
        .col_n        (col_n),
        .row_n        (row_n),
        .link_clk_i   (clk_line),
        .link_clk_o   (kb_clk_o),
        .link_dat_i   (dat_line),
        .link_dat_o   (kb_dat_o),
        .rx_byte      (rx_byte),
        .rx_valid     (rx_valid),
        .overflow     (overflow)
    );

    // line monitor, sampled away from the active edge
    logic [7:0] got [256];
    int   got_n = 0, nb = 0, cyc = 0, last_fall = 0;
    int   per_err = 0, dat_err = 0, rxdat_err = 0, rx_cnt = 0;
    logic [7:0] shreg = '0, rx_last = '0;
    logic clk_prev = 1'b1, dat_prev = 1'b1;
    bit   host_mode = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !host_mode) begin
            if (clk_prev && !clk_line) begin
                if (nb != 0 && (cyc - last_fall) != 12) per_err++;
                last_fall = cyc;
            end
            if (!clk_prev && clk_line) begin
                if ((cyc - last_fall) != 6) per_err++;
                shreg = {dat_line, shreg[7:1]};
                nb++;
                if (nb == 8) begin
                    got[got_n[7:0]] = shreg;
                    got_n++;
                    nb = 0;
                end
            end
            if (nb != 0 && clk_prev && clk_line && dat_line != dat_prev) dat_err++;
        end
        if (host_mode && !kb_dat_o) rxdat_err++;
        if (rx_valid) begin
            rx_last = rx_byte;
            rx_cnt++;
        end
        clk_prev = clk_line;
        dat_prev = dat_line;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_for(input int target, input int lim);
        int t = 0;
        while (got_n < target && t < lim) begin
            @(negedge clk);
            t++;
        end
    endtask

    function automatic logic [7:0] code_of(input bit rel, input int r, input int c);
        logic [3:0] rr = r[3:0];
        logic [2:0] cc = c[2:0];
        return {rel, rr, cc};
    endfunction

    // flip the keys named by mask in row r, then compare the codes received
    task automatic toggle_row(input int r, input logic [7:0] mask, input string req);
        logic [7:0] ex [8];
        int n = 0;
        int base = got_n;
        for (int c = 0; c < 8; c++) begin
            if (mask[c]) begin
                ex[n] = code_of(keys[r*8+c], r, c);
                n++;
            end
        end
        @(negedge clk);
        keys[r*8 +: 8] = keys[r*8 +: 8] ^ mask;
        wait_for(base + n, 4000);
        repeat (900) @(negedge clk);
        chk(got_n == base + n, req, got_n - base, n);
        for (int i = 0; i < n; i++)
            chk(got[(base+i) & 255] == ex[i], req, got[(base+i) & 255], ex[i]);
    endtask

    task automatic scan_watch(input int period, input int nchg, input string req);
        logic [15:0] pr = row_n;
        int run = 0, chg = 0, per_bad = 0, ord_bad = 0, oc_bad = 0;
        bit first = 1'b1;
        while (chg < nchg) begin
            @(negedge clk);
            run++;
            if ($countones(row_n) != 15) oc_bad++;
            if (row_n != pr) begin
                if (row_n != {pr[14:0], pr[15]}) ord_bad++;
                if (!first && run != period) per_bad++;
                first = 1'b0;
                run = 0;
                chg++;
                pr = row_n;
            end
        end
        chk(oc_bad == 0, "R2 one row low", oc_bad, 0);
        chk(ord_bad == 0, "R2 ascending row order", ord_bad, 0);
        chk(per_bad == 0, req, per_bad, 0);
    endtask

    task automatic quiet_line();
        int q = 0;
        while (q < 20) begin
            @(negedge clk);
            if (clk_line && nb == 0) q++; else q = 0;
        end
    endtask

    task automatic host_send(input logic [7:0] b);
        int rc0;
        quiet_line();
        rc0 = rx_cnt;
        host_mode = 1'b1;
        host_clk = 1'b0;
        repeat (20) @(negedge clk);
        host_clk = 1'b1;
        for (int i = 0; i < 8; i++) begin
            do @(negedge clk); while (clk_line);
            host_dat = b[i];
            do @(negedge clk); while (!clk_line);
        end
        host_dat = 1'b1;
        repeat (20) @(negedge clk);
        host_mode = 1'b0;
        chk(rx_cnt == rc0 + 1, "R9 one receive strobe", rx_cnt - rc0, 1);
        chk(rx_last == b, "R9 received byte", rx_last, b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int base;
        logic [7:0] mask;
        void'($urandom(32'd2024));

        // R1: reset state
        repeat (5) @(negedge clk);
        chk(row_n == 16'hFFFE, "R1 row0 in reset", row_n, 16'hFFFE);
        chk(kb_clk_o && kb_dat_o, "R1 lines released", {kb_clk_o, kb_dat_o}, 3);
        chk(!overflow && !rx_valid, "R1 flags clear", {overflow, rx_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(row_n == 16'hFFFE, "R1 row0 after reset", row_n, 16'hFFFE);

        // R2 / R3: order and hold time at settle 3
        scan_watch(12, 40, "R3 hold settle 3");

        // R4: directed codes including the spare corner
        toggle_row(0, 8'h01, "R4 press r0c0");
        toggle_row(0, 8'h01, "R4 release r0c0");
        toggle_row(15, 8'h80, "R4 press r15c7");
        toggle_row(15, 8'h80, "R4 release r15c7");

        // R4: random single keys
        for (int k = 0; k < 5; k++) begin
            int r = $urandom_range(0, 15);
            int c = $urandom_range(0, 7);
            toggle_row(r, 8'(1 << c), "R4 random press");
            toggle_row(r, 8'(1 << c), "R4 random release");
        end

        // R6: several keys of one row, ascending columns
        for (int k = 0; k < 3; k++) begin
            int r = $urandom_range(0, 15);
            mask = 8'($urandom_range(1, 255));
            while ($countones(mask) > 4) mask = mask & (mask - 8'd1);
            toggle_row(r, mask, "R6 group press");
            toggle_row(r, mask, "R6 group release");
        end

        // R5: a press seen on a single scan only
        base = got_n;
        do @(negedge clk); while (!row_n[9]);
        do @(negedge clk); while (row_n[9]);
        keys[9*8+2] = 1'b1;
        do @(negedge clk); while (!row_n[9]);
        keys[9*8+2] = 1'b0;
        repeat (900) @(negedge clk);
        chk(got_n == base, "R5 glitch ignored", got_n - base, 0);

        // R8: eight changes at once, four slots plus the frame in flight
        chk(overflow == 1'b0, "R8 no overflow yet", overflow, 0);
        base = got_n;
        @(negedge clk);
        keys[5*8 +: 8] = 8'hFF;
        wait_for(base + 5, 4000);
        repeat (1200) @(negedge clk);
        chk(got_n == base + 5, "R8 press codes kept", got_n - base, 5);
        for (int i = 0; i < 5; i++)
            chk(got[(base+i) & 255] == 8'h28 + 8'(i), "R8 press order", got[(base+i) & 255], 8'h28 + i);
        chk(overflow == 1'b1, "R8 overflow set", overflow, 1);
        base = got_n;
        keys[5*8 +: 8] = 8'h00;
        wait_for(base + 5, 4000);
        repeat (1200) @(negedge clk);
        chk(got_n == base + 5, "R8 release codes kept", got_n - base, 5);
        for (int i = 0; i < 5; i++)
            chk(got[(base+i) & 255] == 8'hA8 + 8'(i), "R8 release order", got[(base+i) & 255], 8'hA8 + i);
        chk(overflow == 1'b1, "R8 overflow sticky", overflow, 1);

        // R9: host-initiated bytes
        base = got_n;
        host_send(8'hA5);
        host_send(8'($urandom_range(0, 255)));
        chk(rxdat_err == 0, "R9 data released", rxdat_err, 0);
        chk(got_n == base, "R9 no stray frames", got_n - base, 0);

        // R7: frame timing and data placement over every frame seen
        chk(per_err == 0, "R7 bit timing", per_err, 0);
        chk(dat_err == 0, "R7 data only while clock low", dat_err, 0);
        chk(clk_line && dat_line, "R7 idle lines high", {clk_line, dat_line}, 3);

        // R3: new settle value
        settle_cycles = 8'd10;
        repeat (40) @(negedge clk);
        scan_watch(19, 20, "R3 hold settle 10");

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule